// File: doc/BRIEF.md
# Full-Speed USB Receive Clock and Data Recovery

This block takes the receive side of a full-speed USB line after the analog transceiver. That line carries 12 Mb/s NRZI data. The block turns it into a stream of plain data bits for the serial interface engine. It runs from a 48 MHz clock, so it sees four clock cycles per bit cell. Three single-bit inputs are brought in through a two-flop synchroniser: the differential receiver output and the two single-ended receiver outputs. A phase counter then decides which of the four cycles to sample.

The block starts tracking on the first transition of the differential level while the line is not in SE0. Every later transition of that level re-centres the phase counter. The sample is then taken two cycles after the transition is seen, which keeps the sample point near the middle of the cell even when the sender's clock drifts. Each sample that is not SE0 yields one data bit with a one-cycle strobe. The bit is 1 when the line level matches the previous non-SE0 sample and 0 when it differs.

A sample taken while both single-ended inputs are low is reported on its own strobe instead of as a data bit. When two consecutive samples are SE0, the block raises an end-of-packet pulse and returns to idle, ready for the next packet.

Top module: `usb_fs_cdr`

## Requirements
- R1: While reset is asserted and right after its release, every strobe output and `trackActive` are low.
- R2: When the tracker is idle and `rxDiff` changes while the line is not SE0, tracking starts. The strobe for that first cell becomes visible 5 clock cycles after the input change: two synchroniser stages, a 2-cycle sample offset and one output register.
- R3: While tracking with no transitions on `rxDiff`, samples repeat every 4 clock cycles.
- R4: Every transition of `rxDiff` while tracking re-centres the sample point, so the next strobe appears 5 cycles after that transition. This holds whether the cell before it lasted 3, 4 or 5 cycles.
- R5: `bitData` is 1 when the sampled `rxDiff` level equals the previous non-SE0 sampled level and 0 when it differs. For the first cell, the previous level is the level before the starting transition.
- R6: `bitStrobe`, `se0Strobe` and `eopStrobe` are single-cycle pulses, and at most one sample is reported per 4-cycle cell.
- R7: While idle, no strobes are produced, and transitions of `rxDiff` that occur during SE0 do not start tracking.
- R8: A sample taken with `rxDp` and `rxDm` both low raises `se0Strobe` instead of `bitStrobe` and leaves the NRZI reference level unchanged.
- R9: The second consecutive SE0 sample raises `eopStrobe` together with `se0Strobe`. In that same cycle `trackActive` is low, and no further strobes follow until a new start.
- R10: A single SE0 sample followed by a non-SE0 sample produces no `eopStrobe`, and decoding continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz sampling clock, four cycles per bit cell |
| rstN | input | 1 | Asynchronous active-low reset |
| rxDiff | input | 1 | Differential receiver output, 1 for the J level |
| rxDp | input | 1 | Single-ended receiver output of the D+ wire |
| rxDm | input | 1 | Single-ended receiver output of the D- wire |
| bitStrobe | output | 1 | One-cycle pulse marking a recovered data bit |
| bitData | output | 1 | NRZI-decoded data bit, valid with `bitStrobe` |
| se0Strobe | output | 1 | One-cycle pulse marking a sample taken in SE0 |
| eopStrobe | output | 1 | One-cycle pulse on the second consecutive SE0 sample |
| trackActive | output | 1 | High while the phase tracker is following a packet |

## Verification
A phase counter left at the wrong value moves every strobe of the packet. This shows up at the ports as a strobe one or more cycles away from the expected cycle, counted from the most recent line transition. It is visible on the very next bit. A corrupted NRZI reference flips `bitData` on the next data strobe. A wrong SE0 run count either raises `eopStrobe` early on a single SE0 or leaves the tracker producing strobes after the packet has ended. Either fault is visible within two bit cells.

// File: rtl/usb_cdr_pkg.sv
package usb_cdr_pkg;

  typedef struct packed {
    logic sampleNow;   // take the current synchronised line state
    logic startTrack;  // tracker leaves idle on this cycle
    logic stopTrack;   // end of packet seen, tracker goes idle
  } cdrStrobes_t;

  typedef enum logic {
    TRK_IDLE   = 1'b0,
    TRK_ACTIVE = 1'b1
  } trackState_t;

endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
  parameter int              WIDTH     = 3,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/cdr_ctrl.sv
module cdr_ctrl
  import usb_cdr_pkg::*;
#(
  parameter int OVERSAMPLE    = 4,
  parameter int SAMPLE_OFFSET = 2,
  parameter int EOP_BITS      = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineEdge,
  input  logic        lineSe0,
  output cdrStrobes_t strobes,
  output logic        trackActive
);

  localparam int PH_W  = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int CNT_W = (EOP_BITS > 1) ? $clog2(EOP_BITS + 1) : 1;
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(OVERSAMPLE - 1);
  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(SAMPLE_OFFSET);
  localparam logic [PH_W-1:0]  PH_AFTER  = PH_W'(1);
  localparam logic [CNT_W-1:0] RUN_LAST  = CNT_W'(EOP_BITS - 1);

  trackState_t      state;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] se0Run;
  logic             startNow;
  logic             sampleNow;
  logic             stopNow;

  assign startNow  = (state == TRK_IDLE) && lineEdge && !lineSe0;
  assign sampleNow = (state == TRK_ACTIVE) && (phase == PH_SAMPLE);
  assign stopNow   = sampleNow && lineSe0 && (se0Run == RUN_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= TRK_IDLE;
      phase  <= '0;
      se0Run <= '0;
    end else if (stopNow) begin
      state  <= TRK_IDLE;
      phase  <= '0;
      se0Run <= '0;
    end else if (startNow) begin
      state  <= TRK_ACTIVE;
      phase  <= PH_AFTER;
      se0Run <= '0;
    end else if (state == TRK_ACTIVE) begin
      if (lineEdge)              phase <= PH_AFTER;
      else if (phase == PH_LAST) phase <= '0;
      else                       phase <= phase + 1'b1;
      if (sampleNow) se0Run <= lineSe0 ? se0Run + 1'b1 : '0;
    end
  end

  assign strobes.sampleNow  = sampleNow;
  assign strobes.startTrack = startNow;
  assign strobes.stopTrack  = stopNow;
  assign trackActive        = (state == TRK_ACTIVE);

  // Samples never fall on adjacent cycles.
  p_sample_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleNow |=> !sampleNow);

  // After an end of packet the tracker is idle and silent.
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopNow |=> (state == TRK_IDLE) && !sampleNow);

  // A starting or tracked edge places the sample two cycles later.
  if (SAMPLE_OFFSET == 2) begin : g_recentre_chk
    p_recentre_r4: assert property (@(posedge clk) disable iff (!rstN)
      (lineEdge && (state == TRK_ACTIVE || !lineSe0) && !stopNow) ##1 !lineEdge
        |=> sampleNow);
  end

endmodule

// File: rtl/cdr_datapath.sv
module cdr_datapath
  import usb_cdr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineLvl,
  input  logic        lineSe0,
  input  cdrStrobes_t strobes,
  output logic        lineEdge,
  output logic        bitStrobe,
  output logic        bitData,
  output logic        se0Strobe,
  output logic        eopStrobe
);

  logic lastLvl;
  logic refLvl;
  logic takeBit;

  assign lineEdge = lineLvl ^ lastLvl;
  assign takeBit  = strobes.sampleNow && !lineSe0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastLvl   <= 1'b1;
      refLvl    <= 1'b1;
      bitStrobe <= 1'b0;
      bitData   <= 1'b0;
      se0Strobe <= 1'b0;
      eopStrobe <= 1'b0;
    end else begin
      lastLvl <= lineLvl;
      if (strobes.startTrack) refLvl <= lastLvl;
      else if (takeBit)       refLvl <= lineLvl;
      bitStrobe <= takeBit;
      if (takeBit) bitData <= ~(lineLvl ^ refLvl);
      se0Strobe <= strobes.sampleNow && lineSe0;
      eopStrobe <= strobes.stopTrack;
    end
  end

  // A decoded 1 means the reference did not move on that sample.
  p_nrzi_ref_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> (bitData == (refLvl == $past(refLvl))));

  // SE0 samples leave the NRZI reference untouched.
  p_se0_ref_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    se0Strobe |-> $stable(refLvl));

  // End of packet is always reported on an SE0 sample.
  p_eop_on_se0_r9: assert property (@(posedge clk) disable iff (!rstN)
    eopStrobe |-> se0Strobe && !bitStrobe);

endmodule

// File: rtl/usb_fs_cdr.sv
module usb_fs_cdr
  import usb_cdr_pkg::*;
#(
  parameter int OVERSAMPLE    = 4,
  parameter int SAMPLE_OFFSET = 2,
  parameter int EOP_BITS      = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxDiff,
  input  logic rxDp,
  input  logic rxDm,
  output logic bitStrobe,
  output logic bitData,
  output logic se0Strobe,
  output logic eopStrobe,
  output logic trackActive
);

  localparam int         LINE_W    = 3;
  localparam logic [2:0] LINE_IDLE = 3'b110;  // {diff, dp, dm} in the J state

  logic [LINE_W-1:0] lineSync;
  logic              lineLvl;
  logic              lineSe0;
  logic              lineEdge;
  cdrStrobes_t       strobes;

  cdr_sync #(
    .WIDTH    (LINE_W),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(LINE_IDLE)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({rxDiff, rxDp, rxDm}),
    .dout(lineSync)
  );

  assign lineLvl = lineSync[2];
  assign lineSe0 = !lineSync[1] && !lineSync[0];

  cdr_ctrl #(
    .OVERSAMPLE   (OVERSAMPLE),
    .SAMPLE_OFFSET(SAMPLE_OFFSET),
    .EOP_BITS     (EOP_BITS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineEdge   (lineEdge),
    .lineSe0    (lineSe0),
    .strobes    (strobes),
    .trackActive(trackActive)
  );

  cdr_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineLvl  (lineLvl),
    .lineSe0  (lineSe0),
    .strobes  (strobes),
    .lineEdge (lineEdge),
    .bitStrobe(bitStrobe),
    .bitData  (bitData),
    .se0Strobe(se0Strobe),
    .eopStrobe(eopStrobe)
  );

  // Data and SE0 reports never coincide.
  p_report_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(bitStrobe && se0Strobe));

endmodule

// File: tb/tb_usb_fs_cdr.sv
module tb_usb_fs_cdr;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxDiff = 1'b1;
  logic rxDp = 1'b1;
  logic rxDm = 1'b0;
  logic bitStrobe, bitData, se0Strobe, eopStrobe, trackActive;

  usb_fs_cdr dut (
    .clk(clk), .rstN(rstN), .rxDiff(rxDiff), .rxDp(rxDp), .rxDm(rxDm),
    .bitStrobe(bitStrobe), .bitData(bitData), .se0Strobe(se0Strobe),
    .eopStrobe(eopStrobe), .trackActive(trackActive)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nBad = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    int    t;
    bit    isSe0;
    bit    data;
    bit    eop;
    string tag;
  } exp_t;
  exp_t expQ[$];

  // Bench model of the expected report schedule.
  bit mActive = 1'b0;
  bit mRef = 1'b1;
  int mSe0Run = 0;
  int mNext = 0;
  bit curDiff = 1'b1;
  int prevLen = 4;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic driveCell(input bit d, input bit se0, input int len);
    int n;
    bit edgeNow;
    exp_t e;
    @(negedge clk);
    n = cyc;
    edgeNow = (d != curDiff);
    rxDiff = d;
    rxDp = se0 ? 1'b0 : d;
    rxDm = se0 ? 1'b0 : !d;
    e.t = -1;
    if (!mActive && edgeNow && !se0) begin
      mActive = 1'b1;
      mRef = curDiff;
      mSe0Run = 0;
      e.t = n + 5;
      e.tag = "R2";
    end else if (mActive) begin
      e.t = edgeNow ? n + 5 : mNext + 4;
      e.tag = (edgeNow && prevLen != 4) ? "R4" : "R3";
    end
    if (e.t >= 0) begin
      e.isSe0 = se0;
      e.data = 1'b0;
      e.eop = 1'b0;
      if (se0) begin
        mSe0Run++;
        e.eop = (mSe0Run == 2);
        if (e.eop) mActive = 1'b0;
      end else begin
        e.data = (d == mRef);
        mRef = d;
        mSe0Run = 0;
      end
      mNext = e.t;
      expQ.push_back(e);
    end
    curDiff = d;
    prevLen = len;
    repeat (len - 1) @(negedge clk);
  endtask

  // Output monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (monOn) begin
      if (expQ.size() > 0 && expQ[0].t < cyc) begin
        check(1'b0, expQ[0].tag, "missed strobe, cycle", cyc, expQ[0].t);
        void'(expQ.pop_front());
      end
      if (bitStrobe || se0Strobe || eopStrobe) begin
        if (expQ.size() > 0 && expQ[0].t == cyc) begin
          exp_t e;
          e = expQ.pop_front();
          check(1'b1, e.tag, "strobe timing", cyc, e.t);
          check(se0Strobe == e.isSe0 && bitStrobe == !e.isSe0, "R8",
                "se0Strobe kind", se0Strobe, e.isSe0);
          if (!e.isSe0) check(bitData == e.data, "R5", "bitData", bitData, e.data);
          check(eopStrobe == e.eop, e.eop ? "R9" : "R10", "eopStrobe",
                eopStrobe, e.eop);
          if (e.eop) check(trackActive == 1'b0, "R9", "trackActive at eop",
                           trackActive, 0);
        end else begin
          check(1'b0, "R6 R7", "unexpected strobe at cycle", cyc,
                expQ.size() > 0 ? expQ[0].t : -1);
        end
      end
    end
  end

  initial begin
    #(150000 * 20);
    if (!finished) begin
      check(1'b0, "watchdog", "run did not finish, cycle", cyc, 150000);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(!bitStrobe && !se0Strobe && !eopStrobe && !trackActive, "R1",
          "outputs during reset", {bitStrobe, se0Strobe, eopStrobe, trackActive}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!bitStrobe && !se0Strobe && !eopStrobe && !trackActive, "R1",
          "outputs after reset", {bitStrobe, se0Strobe, eopStrobe, trackActive}, 0);
    monOn = 1'b1;
    repeat (8) driveCell(1'b1, 1'b0, 4);
    check(trackActive == 1'b0, "R7", "trackActive on idle J", trackActive, 0);

    // Sweep over every byte value, with cell-length jitter before edges.
    for (int p = 0; p < 256; p++) begin
      bit lvl[9];
      lvl[0] = 1'b0;
      for (int i = 1; i < 9; i++) lvl[i] = p[i-1] ? lvl[i-1] : !lvl[i-1];
      for (int i = 0; i < 9; i++) begin
        bit nextLvl;
        int len;
        nextLvl = (i < 8) ? lvl[i+1] : 1'b1;
        len = (nextLvl != lvl[i]) ? 3 + ((p + i) % 3) : 4;
        driveCell(lvl[i], 1'b0, len);
      end
      driveCell(1'b1, 1'b1, 4);
      driveCell(1'b1, 1'b1, 4);
      repeat (3) driveCell(1'b1, 1'b0, 4);
      check(trackActive == 1'b0, "R9", "trackActive after packet", trackActive, 0);
    end

    // R10: isolated SE0 sample inside a packet, reference held across it (R8).
    driveCell(1'b0, 1'b0, 4);
    driveCell(1'b0, 1'b0, 4);
    driveCell(1'b0, 1'b1, 4);
    driveCell(1'b0, 1'b0, 4);
    driveCell(1'b1, 1'b0, 4);
    driveCell(1'b1, 1'b1, 4);
    driveCell(1'b1, 1'b1, 4);
    repeat (3) driveCell(1'b1, 1'b0, 4);

    // R7: transitions during SE0 while idle must not start tracking.
    driveCell(1'b0, 1'b1, 4);
    driveCell(1'b1, 1'b1, 4);
    driveCell(1'b0, 1'b1, 4);
    check(trackActive == 1'b0, "R7", "trackActive after SE0 edges", trackActive, 0);
    driveCell(1'b1, 1'b1, 4);
    repeat (4) driveCell(1'b1, 1'b0, 4);
    check(trackActive == 1'b0, "R7", "trackActive back on J", trackActive, 0);

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R3", "pending expected strobes", expQ.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule